// File: doc/BRIEF.md
# Vector predicate while-mask generator

This unit turns an active-lane count into a vector predicate mask and its condition flags. The caller supplies the operation size in predicate bytes, an element-size code, a count in predicate-bit units and a fill direction. The predicate width in bits is the size times eight. In low-fill mode the unit enables the lowest `count` predicate bits. In high-fill mode it enables the topmost `count` bits below the width. In both modes only the bits that begin an element of the selected size are kept.

The N, Z and C flags are not found by testing the finished mask. They follow from the count and the width alone, with a separate N/C rule for each direction, so the flag path does not wait on a scan of the mask. A count that exceeds the width, or a size above the supported maximum, raises an error output and clears the mask. All results are registered and appear one cycle after an input strobe, together with a one-cycle valid pulse.

Top module: `pwm_while_gen`

## Requirements
- R1: The operation width in predicate bits is `size_bytes` × 8. No mask bit at or above that width is ever set.
- R2: In low-fill mode (`fill_high`=0), mask bit i is set exactly when i < count and bit i is kept by the element-size rule.
- R3: In high-fill mode (`fill_high`=1), mask bit i is set exactly when width − count ≤ i < width and bit i is kept by the element-size rule.
- R4: Element-size rule: `elem_size` 0 keeps every bit, 1 keeps every 2nd bit, 2 keeps every 4th bit and 3 keeps every 8th bit, in each case starting at bit 0.
- R5: The flag word carries N at bit 31, the inverse of Z at bit 1 and C at bit 0. Every other bit is 0.
- R6: A count of zero gives an all-zero mask and the flag word 32'h0000_0001 (N=0, Z=1, C=1) in either mode.
- R7: In low-fill mode with a nonzero count, N=1 and Z=0, and C=1 exactly when the count differs from the width. The flag word is therefore 32'h8000_0003, or 32'h8000_0002 at full width.
- R8: In high-fill mode with a nonzero count, Z=0 and C=0, and N=1 exactly when the count equals the width. The flag word is therefore 32'h0000_0002, or 32'h8000_0002 at full width.
- R9: If the count exceeds the width, or `size_bytes` exceeds 32, then `out_err`=1, the mask is all zero and the flag word is 32'h0000_0001. Otherwise `out_err`=0.
- R10: The mask, flags and error for a strobed input appear on the first rising edge after the strobe, and `out_valid` is high for exactly that one cycle. Without a strobe, the outputs hold their values.
- R11: While reset is active, and until the first strobe after it, `out_valid`, `out_err`, `out_mask` and `out_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| size_bytes | input | 6 | Operation size in predicate bytes |
| elem_size | input | 2 | Element-size code (0 byte, 1 half, 2 word, 3 double) |
| count | input | 9 | Active count in predicate bits |
| fill_high | input | 1 | 0: fill from bit 0 upward; 1: fill downward from the width |
| out_valid | output | 1 | One-cycle pulse marking new results |
| out_mask | output | 256 | Predicate mask |
| out_flags | output | 32 | Packed N/Z/C flag word |
| out_err | output | 1 | Count or size out of range |

## Verification
Every result (mask, flag word, error bit and valid pulse) is due on the first rising edge after the strobe, because one register stage separates it from the inputs. The bench drives a strobe on a falling edge and samples all four outputs on the next falling edge, which falls half a cycle after that rising edge. It then samples once more a cycle later, with the strobe low. That second sample confirms that `out_valid` has dropped and that the other outputs still hold their values.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int FLAG_N  = 31;
  localparam int FLAG_NZ = 1;
  localparam int FLAG_C  = 0;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_DBL  = 2'd3
  } esz_e;

  // A predicate bit is kept when it is the lowest bit of an element.
  function automatic logic lane_kept(int unsigned idx, logic [1:0] esz);
    int unsigned step;
    step = 32'd1 << esz;
    return (idx & (step - 1)) == 0;
  endfunction

  // Flag word computed from the count and the width only.
  function automatic logic [31:0] count_flags(int unsigned width, int unsigned cnt,
                                              logic high);
    logic [31:0] f;
    f = '0;
    if (cnt == 0) begin
      f[FLAG_C] = 1'b1;
    end else if (!high) begin
      f[FLAG_N]  = 1'b1;
      f[FLAG_NZ] = 1'b1;
      f[FLAG_C]  = (cnt != width);
    end else begin
      f[FLAG_NZ] = 1'b1;
      f[FLAG_N]  = (cnt == width);
    end
    return f;
  endfunction

endpackage

// File: rtl/pwm_elem_mask.sv
module pwm_elem_mask #(
  parameter int MASK_W = 256
) (
  input  logic [1:0]        esz,
  output logic [MASK_W-1:0] keep
);
  import pwm_pkg::*;

  for (genvar i = 0; i < MASK_W; i++) begin : g_keep
    assign keep[i] = lane_kept(i, esz);
  end
endmodule

// File: rtl/pwm_span_dec.sv
module pwm_span_dec #(
  parameter int MASK_W = 256,
  parameter int CMP_W  = 9
) (
  input  logic [CMP_W-1:0]  width,
  input  logic [CMP_W-1:0]  cnt,
  input  logic              high,
  output logic [MASK_W-1:0] span
);
  logic [CMP_W-1:0] lo_edge;

  // Lowest enabled position in high-fill mode; out-of-range counts are masked later.
  assign lo_edge = width - cnt;

  for (genvar i = 0; i < MASK_W; i++) begin : g_span
    localparam logic [CMP_W-1:0] IDX = CMP_W'(i);
    logic in_low, in_high;
    assign in_low  = IDX < cnt;
    assign in_high = (IDX >= lo_edge) && (IDX < width);
    assign span[i] = high ? in_high : in_low;
  end
endmodule

// File: rtl/pwm_flag_gen.sv
module pwm_flag_gen #(
  parameter int CMP_W = 9
) (
  input  logic [CMP_W-1:0] width,
  input  logic [CMP_W-1:0] cnt,
  input  logic             high,
  input  logic             err,
  output logic [31:0]      flags
);
  import pwm_pkg::*;

  always_comb begin
    if (err) flags = count_flags(0, 0, 1'b0);
    else     flags = count_flags(int'(width), int'(cnt), high);
  end
endmodule

// File: rtl/pwm_while_gen.sv
module pwm_while_gen #(
  parameter int MASK_W    = 256,
  parameter int MAX_BYTES = MASK_W / 8,
  parameter int SZ_W      = $clog2(MAX_BYTES + 2),
  parameter int CNT_W     = $clog2(MASK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SZ_W-1:0]   size_bytes,
  input  logic [1:0]        elem_size,
  input  logic [CNT_W-1:0]  count,
  input  logic              fill_high,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask,
  output logic [31:0]       out_flags,
  output logic              out_err
);
  localparam int WID_W = SZ_W + 3;
  localparam int CMP_W = (WID_W > CNT_W) ? WID_W : CNT_W;

  logic [CMP_W-1:0]  width_bits;
  logic [CMP_W-1:0]  cnt_ext;
  logic              size_over;
  logic              count_over;
  logic              req_err;
  logic [MASK_W-1:0] keep_vec;
  logic [MASK_W-1:0] span_vec;
  logic [MASK_W-1:0] mask_next;
  logic [31:0]       flags_next;

  assign width_bits = CMP_W'({size_bytes, 3'b000});
  assign cnt_ext    = CMP_W'(count);
  assign size_over  = size_bytes > SZ_W'(MAX_BYTES);
  assign count_over = cnt_ext > width_bits;
  assign req_err    = size_over || count_over;

  pwm_elem_mask #(.MASK_W(MASK_W)) u_keep (
    .esz  (elem_size),
    .keep (keep_vec)
  );

  pwm_span_dec #(.MASK_W(MASK_W), .CMP_W(CMP_W)) u_span (
    .width (width_bits),
    .cnt   (cnt_ext),
    .high  (fill_high),
    .span  (span_vec)
  );

  pwm_flag_gen #(.CMP_W(CMP_W)) u_flags (
    .width (width_bits),
    .cnt   (cnt_ext),
    .high  (fill_high),
    .err   (req_err),
    .flags (flags_next)
  );

  assign mask_next = req_err ? '0 : (span_vec & keep_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_flags <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask  <= mask_next;
        out_flags <= flags_next;
        out_err   <= req_err;
      end
    end
  end
endmodule

// File: rtl/pwm_while_chk.sv
module pwm_while_chk #(
  parameter int MASK_W = 256,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              fill_high,
  input logic [CNT_W-1:0]  count,
  input logic              req_err,
  input logic              out_valid,
  input logic [MASK_W-1:0] out_mask,
  input logic [31:0]       out_flags,
  input logic              out_err
);
  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_mask) && $stable(out_flags) && $stable(out_err));

  // R9
  err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_err == $past(req_err));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_mask == '0) && (out_flags == 32'h1));

  // R5
  flag_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flags & 32'h7FFF_FFFC) == 32'h0);

  // R7
  low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && !$past(fill_high) && ($past(count) != '0)
      |-> out_flags[31] && out_flags[1] && out_mask[0]);

  // R8
  high_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && $past(fill_high) && ($past(count) != '0)
      |-> out_flags[1] && !out_flags[0]);
endmodule

bind pwm_while_gen pwm_while_chk #(.MASK_W(MASK_W), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .fill_high (fill_high),
  .count     (count),
  .req_err   (req_err),
  .out_valid (out_valid),
  .out_mask  (out_mask),
  .out_flags (out_flags),
  .out_err   (out_err)
);

// File: tb/test_pwm_while_gen.sv
`timescale 1ns/1ps
module test_pwm_while_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [5:0]   size_bytes = '0;
  logic [1:0]   elem_size = '0;
  logic [8:0]   count = '0;
  logic         fill_high = 1'b0;
  logic         out_valid;
  logic [255:0] out_mask;
  logic [31:0]  out_flags;
  logic         out_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_while_gen i_pwm_while_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_bytes(size_bytes),
    .elem_size(elem_size), .count(count), .fill_high(fill_high),
    .out_valid(out_valid), .out_mask(out_mask), .out_flags(out_flags), .out_err(out_err)
  );

  typedef struct packed {
    logic [5:0]  sz;
    logic [1:0]  es;
    logic [8:0]  cn;
    logic        hi;
    logic [31:0] fl;
    logic        er;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'd32, 2'd0, 9'd0,   1'b0, 32'h0000_0001, 1'b0},
    '{6'd32, 2'd0, 9'd256, 1'b0, 32'h8000_0002, 1'b0},
    '{6'd32, 2'd0, 9'd5,   1'b0, 32'h8000_0003, 1'b0},
    '{6'd4,  2'd1, 9'd32,  1'b0, 32'h8000_0002, 1'b0},
    '{6'd4,  2'd2, 9'd17,  1'b0, 32'h8000_0003, 1'b0},
    '{6'd32, 2'd0, 9'd256, 1'b1, 32'h8000_0002, 1'b0},
    '{6'd8,  2'd3, 9'd20,  1'b1, 32'h0000_0002, 1'b0},
    '{6'd2,  2'd0, 9'd0,   1'b1, 32'h0000_0001, 1'b0},
    '{6'd2,  2'd0, 9'd17,  1'b0, 32'h0000_0001, 1'b1},
    '{6'd33, 2'd0, 9'd1,   1'b0, 32'h0000_0001, 1'b1},
    '{6'd1,  2'd1, 9'd8,   1'b1, 32'h8000_0002, 1'b0},
    '{6'd16, 2'd2, 9'd100, 1'b1, 32'h0000_0002, 1'b0}
  };

  // Reference mask: walk the element starts and test each against the window.
  function automatic logic [255:0] ref_mask(int sz, int es, int cn, bit hi);
    logic [255:0] m;
    int w;
    m = '0;
    w = sz * 8;
    if (sz > 32 || cn > w) return m;
    for (int e = 0; e < w; e += (1 << es)) begin
      if (hi ? (e >= w - cn) : (e < cn)) m[e] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic apply(int sz, int es, int cn, bit hi);
    @(negedge clk);
    size_bytes = 6'(sz);
    elem_size  = 2'(es);
    count      = 9'(cn);
    fill_high  = hi;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [255:0] m_prev;
    logic [31:0]  f_prev;
    // R11 during and after reset
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_err == 0 && out_mask == '0 && out_flags == '0,
          "R11", "reset state", {out_valid, out_err, out_flags}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 0 && out_mask == '0 && out_flags == '0,
          "R11", "idle after reset", {out_valid, out_flags}, '0);

    for (int k = 0; k < NV; k++) begin
      logic [255:0] em;
      string mtag, ftag;
      em   = ref_mask(VECS[k].sz, VECS[k].es, VECS[k].cn, VECS[k].hi);
      mtag = VECS[k].er ? "R9" : (VECS[k].cn == 0 ? "R6" : (VECS[k].hi ? "R3" : "R2"));
      ftag = VECS[k].er ? "R9" : (VECS[k].cn == 0 ? "R6" : (VECS[k].hi ? "R8" : "R7"));
      apply(VECS[k].sz, VECS[k].es, VECS[k].cn, VECS[k].hi);
      check(out_valid == 1'b1, "R10", "valid pulse", 256'(out_valid), 256'(1));
      check(out_mask == em, mtag, "mask", out_mask, em);
      check(out_flags == VECS[k].fl, ftag, "flags", 256'(out_flags), 256'(VECS[k].fl));
      check(out_err == VECS[k].er, "R9", "error bit", 256'(out_err), 256'(VECS[k].er));
      check((out_flags & 32'h7FFF_FFFC) == 0, "R5", "reserved flag bits",
            256'(out_flags), 256'(out_flags & 32'h8000_0003));
    end

    // R4 element-size patterns
    apply(4, 2, 32, 1'b0);
    check(out_mask == 256'h1111_1111, "R4", "word pattern", out_mask, 256'h1111_1111);
    apply(4, 1, 32, 1'b0);
    check(out_mask == 256'h5555_5555, "R4", "half pattern", out_mask, 256'h5555_5555);
    apply(8, 3, 64, 1'b1);
    check(out_mask == 256'h0101_0101_0101_0101, "R4", "double pattern",
          out_mask, 256'h0101_0101_0101_0101);

    // R1 nothing at or above the width
    apply(2, 0, 16, 1'b1);
    check(out_mask[255:16] == '0 && out_mask[15:0] == 16'hFFFF, "R1", "width bound",
          out_mask, 256'hFFFF);
    apply(3, 0, 5, 1'b1);
    check(out_mask == 256'h00F8_0000, "R1", "high fill top at width", out_mask, 256'h00F8_0000);

    // R10 hold without strobe
    m_prev = out_mask;
    f_prev = out_flags;
    @(negedge clk);
    size_bytes = 6'd32; count = 9'd256; fill_high = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R10", "valid drops", 256'(out_valid), 256'(0));
    check(out_mask == m_prev && out_flags == f_prev, "R10", "hold mask", out_mask, m_prev);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule